// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block is the architectural register store of a 32-bit processor core. Software sees sixteen general registers, a current status word and a saved status word. Which physical copy backs each visible register follows the processor mode held in the low five bits of the current status word. The low eight registers are common to every mode. Registers 8 to 12 have a second copy that only fast-interrupt mode uses. The stack pointer (13) and link register (14) have one copy for each exception mode, plus one copy that user and system mode share. Register 15 is the program counter. A read of it returns the pipeline-adjusted value, the stored address plus 8.

The block has two combinational read ports, one synchronous write port and a program-counter increment input. It also has read and write ports for the current status word and for the saved status word of the current mode. An exception-entry strobe saves the current status word into the target mode's saved slot and switches the mode field in the same edge. Only the five exception modes have a saved status slot. User mode, system mode and undefined mode codes read the saved status as zero and ignore writes to it.

Top module: `banked_regfile`

## Requirements
- R1: While `rst_n` is low at a rising edge, every physical register, the program counter and all five saved status slots clear to zero. The current status word becomes 0x00000013 (supervisor mode).
- R2: Registers 0 to 7 name the same storage in every mode. A value written in one mode reads back unchanged in any other mode.
- R3: Registers 8 to 12 have two copies. Fast-interrupt mode (mode field 10001) uses one copy, and every other mode uses the other.
- R4: Registers 13 and 14 have six copies. User (10000) and system (11111) share one copy. Fast interrupt (10001), interrupt (10010), supervisor (10011), abort (10111) and undefined (11011) each have their own.
- R5: The mode is the current status word's bits [4:0]. Any code not listed in R4 selects the user copies and has no saved status slot.
- R6: A read of register 15 returns the stored program counter plus 8. A write to register 15 loads `wr_data` unadjusted. In a cycle without such a write, `pc_inc` high adds 4 to the program counter.
- R7: Reads are combinational. A read of the register being written in the same cycle returns the old value, and the new value is visible from the next cycle.
- R8: `exc_enter` with `exc_mode` naming an exception mode copies the current status word into that mode's saved slot. At the same edge it replaces bits [4:0] of the current status word with `exc_mode` and keeps all other bits. With a non-exception `exc_mode` the strobe has no effect.
- R9: In a mode without a saved slot, `saved_q` reads zero and `saved_wr_en` alters no saved slot. In an exception mode it reads or writes that mode's slot.
- R10: An effective exception entry takes priority over `psr_wr_en` and `saved_wr_en` in the same cycle. Both writes are dropped.
- R11: The two read ports are independent. Each returns the register its own address selects in the current mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_addr_a | input | 4 | Read port A register index |
| rd_data_a | output | 32 | Read port A data |
| rd_addr_b | input | 4 | Read port B register index |
| rd_data_b | output | 32 | Read port B data |
| wr_en | input | 1 | General register write enable |
| wr_addr | input | 4 | Write register index |
| wr_data | input | 32 | Write data |
| pc_inc | input | 1 | Advance program counter by 4 when not written |
| psr_wr_en | input | 1 | Current status word write enable |
| psr_wr_data | input | 32 | Current status word write data |
| psr_q | output | 32 | Current status word |
| saved_wr_en | input | 1 | Saved status write enable for the current mode |
| saved_wr_data | input | 32 | Saved status write data |
| saved_q | output | 32 | Saved status word of the current mode, zero if none |
| exc_enter | input | 1 | Exception-entry strobe |
| exc_mode | input | 5 | Mode code being entered |

## Verification
An exception entry can fall in the same cycle as a write to the current status word or to the saved status word, and the mode switch then decides which banks later accesses see. Directed cases assert `exc_enter` together with both status writes, with valid and invalid target codes. The random phase also lets these strobes coincide freely. A bench model computes the expected results: the old status word lands in the target slot, the mode field takes the new code, and the dropped writes leave no trace in later reads of any bank.

// File: rtl/brf_pkg.sv
// brf_pkg: shared constants, mode codes and physical-slot mapping for the
// banked register file. Assumes the 16-register architectural view.
package brf_pkg;
    localparam int NSHARED     = 8;   // registers common to all modes
    localparam int NHIGH       = 5;   // registers 8..12
    localparam int NSTK_BANKS  = 6;   // copies of 13/14
    localparam int NSTK_REGS   = 2;   // registers 13 and 14
    localparam int NSAVED      = 5;   // saved status slots
    localparam int NSTORE      = NSHARED + 2*NHIGH + NSTK_BANKS*NSTK_REGS;
    localparam int HIGH_FIQ_BASE = NSHARED + NHIGH;
    localparam int STK_BASE      = NSHARED + 2*NHIGH;
    localparam int SIDX_W      = $clog2(NSTORE);
    localparam int BANK_W      = $clog2(NSTK_BANKS);
    localparam int SLOT_W      = $clog2(NSAVED);

    typedef enum logic [4:0] {
        MODE_USR = 5'b10000,
        MODE_FIQ = 5'b10001,
        MODE_IRQ = 5'b10010,
        MODE_SVC = 5'b10011,
        MODE_ABT = 5'b10111,
        MODE_UND = 5'b11011,
        MODE_SYS = 5'b11111
    } mode_e;

    // Map a visible register (0..14) to its physical storage slot.
    function automatic logic [SIDX_W-1:0] phys_slot(
        input logic [3:0]        vis,
        input logic              fiq,
        input logic [BANK_W-1:0] stk
    );
        int s;
        if (vis < 4'd8)
            s = int'(vis);
        else if (vis < 4'd13)
            s = fiq ? int'(vis) - NSHARED + HIGH_FIQ_BASE : int'(vis);
        else
            s = STK_BASE + int'(stk)*NSTK_REGS + (int'(vis) - 13);
        return SIDX_W'(s);
    endfunction
endpackage

// File: rtl/brf_mode_decode.sv
// brf_mode_decode: turns a 5-bit mode code into bank selectors.
// Assumes unlisted codes behave as user mode (user stack bank, no saved slot).
module brf_mode_decode
    import brf_pkg::*;
(
    input  logic [4:0]        mode,
    output logic              is_fiq,
    output logic [BANK_W-1:0] stk_bank,
    output logic              has_saved,
    output logic [SLOT_W-1:0] saved_slot
);
    // Decode mode code into bank and saved-slot selection.
    always_comb begin
        is_fiq     = 1'b0;
        stk_bank   = '0;
        has_saved  = 1'b0;
        saved_slot = '0;
        case (mode)
            MODE_FIQ: begin is_fiq = 1'b1; stk_bank = BANK_W'(1); has_saved = 1'b1; saved_slot = SLOT_W'(0); end
            MODE_IRQ: begin stk_bank = BANK_W'(2); has_saved = 1'b1; saved_slot = SLOT_W'(1); end
            MODE_SVC: begin stk_bank = BANK_W'(3); has_saved = 1'b1; saved_slot = SLOT_W'(2); end
            MODE_ABT: begin stk_bank = BANK_W'(4); has_saved = 1'b1; saved_slot = SLOT_W'(3); end
            MODE_UND: begin stk_bank = BANK_W'(5); has_saved = 1'b1; saved_slot = SLOT_W'(4); end
            default:  begin stk_bank = '0; end
        endcase
    end
endmodule

// File: rtl/brf_gpr_store.sv
// brf_gpr_store: physical general registers and the program counter.
// Two combinational reads, one synchronous write; bank selection comes from
// the current mode decode. Assumes writes use the mode in force before the edge.
module brf_gpr_store
    import brf_pkg::*;
#(
    parameter int DW       = 32,
    parameter int PC_STEP  = 4,
    parameter int PC_AHEAD = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              is_fiq,
    input  logic [BANK_W-1:0] stk_bank,
    input  logic [3:0]        rd_addr_a,
    output logic [DW-1:0]     rd_data_a,
    input  logic [3:0]        rd_addr_b,
    output logic [DW-1:0]     rd_data_b,
    input  logic              wr_en,
    input  logic [3:0]        wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic              pc_inc
);
    localparam logic [3:0] PC_IDX = 4'd15;

    logic [DW-1:0]     store [NSTORE];
    logic [DW-1:0]     pc_r;
    logic [SIDX_W-1:0] w_slot;
    logic              wr_pc;
    logic              wr_gpr;

    // Resolve write target in the current mode.
    always_comb begin
        w_slot = phys_slot(wr_addr, is_fiq, stk_bank);
        wr_pc  = wr_en && (wr_addr == PC_IDX);
        wr_gpr = wr_en && (wr_addr != PC_IDX);
    end

    // Read ports: banked lookup, program counter seen ahead by the pipeline.
    always_comb begin
        rd_data_a = (rd_addr_a == PC_IDX) ? pc_r + DW'(PC_AHEAD)
                  : store[phys_slot(rd_addr_a, is_fiq, stk_bank)];
        rd_data_b = (rd_addr_b == PC_IDX) ? pc_r + DW'(PC_AHEAD)
                  : store[phys_slot(rd_addr_b, is_fiq, stk_bank)];
    end

    // Physical register update and clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NSTORE; i++) store[i] <= '0;
        end else if (wr_gpr) begin
            store[w_slot] <= wr_data;
        end
    end

    // Program counter: direct load wins over increment.
    always_ff @(posedge clk) begin
        if (!rst_n)      pc_r <= '0;
        else if (wr_pc)  pc_r <= wr_data;
        else if (pc_inc) pc_r <= pc_r + DW'(PC_STEP);
    end

    // R7
    gpr_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_gpr |=> store[$past(w_slot)] == $past(wr_data));
    // R6
    pc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pc |=> pc_r == $past(wr_data));
    // R6
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_pc && pc_inc) |=> pc_r == $past(pc_r) + DW'(PC_STEP));
endmodule

// File: rtl/brf_psr_unit.sv
// brf_psr_unit: current status word and the five saved status slots.
// Exception entry saves the status word and switches mode in one edge and
// overrides status writes; saved accesses need a mode that owns a slot.
module brf_psr_unit
    import brf_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cur_has_saved,
    input  logic [SLOT_W-1:0] cur_slot,
    input  logic              tgt_has_saved,
    input  logic [SLOT_W-1:0] tgt_slot,
    input  logic              exc_enter,
    input  logic [4:0]        exc_mode,
    input  logic              psr_wr_en,
    input  logic [DW-1:0]     psr_wr_data,
    input  logic              saved_wr_en,
    input  logic [DW-1:0]     saved_wr_data,
    output logic [DW-1:0]     psr_q,
    output logic [DW-1:0]     saved_q
);
    logic [DW-1:0]                 cpsr_r;
    logic [NSAVED-1:0][DW-1:0]     saved_r;
    logic                          take_exc;

    // An entry counts only when the target owns a saved slot.
    assign take_exc = exc_enter && tgt_has_saved;

    // Status outputs; modes without a slot read zero.
    always_comb begin
        psr_q   = cpsr_r;
        saved_q = cur_has_saved ? saved_r[cur_slot] : '0;
    end

    // Status word and saved slots update with entry priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpsr_r  <= DW'(MODE_SVC);
            saved_r <= '0;
        end else if (take_exc) begin
            saved_r[tgt_slot] <= cpsr_r;
            cpsr_r[4:0]       <= exc_mode;
        end else begin
            if (psr_wr_en)                  cpsr_r            <= psr_wr_data;
            if (saved_wr_en && cur_has_saved) saved_r[cur_slot] <= saved_wr_data;
        end
    end

    // R1
    rst_state_chk: assert property (@(posedge clk)
        !rst_n |=> (cpsr_r == DW'(MODE_SVC) && saved_r == '0));
    // R8
    exc_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_exc |=> saved_r[$past(tgt_slot)] == $past(cpsr_r));
    // R10
    exc_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_exc |=> (cpsr_r[4:0] == $past(exc_mode) && cpsr_r[DW-1:5] == $past(cpsr_r[DW-1:5])));
    // R9
    no_slot_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cur_has_saved && !take_exc) |=> $stable(saved_r));
endmodule

// File: rtl/banked_regfile.sv
// banked_regfile: top of the mode-banked register file. Decodes the current
// mode from the status word and the exception target, then drives the general
// store and the status unit. Assumes a single write port per cycle.
module banked_regfile
    import brf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  rd_addr_a,
    output logic [31:0] rd_data_a,
    input  logic [3:0]  rd_addr_b,
    output logic [31:0] rd_data_b,
    input  logic        wr_en,
    input  logic [3:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic        pc_inc,
    input  logic        psr_wr_en,
    input  logic [31:0] psr_wr_data,
    output logic [31:0] psr_q,
    input  logic        saved_wr_en,
    input  logic [31:0] saved_wr_data,
    output logic [31:0] saved_q,
    input  logic        exc_enter,
    input  logic [4:0]  exc_mode
);
    logic              cur_fiq, tgt_fiq;
    logic [BANK_W-1:0] cur_stk, tgt_stk;
    logic              cur_has, tgt_has;
    logic [SLOT_W-1:0] cur_slot, tgt_slot;

    brf_mode_decode u_cur_dec (
        .mode(psr_q[4:0]), .is_fiq(cur_fiq), .stk_bank(cur_stk),
        .has_saved(cur_has), .saved_slot(cur_slot)
    );

    brf_mode_decode u_tgt_dec (
        .mode(exc_mode), .is_fiq(tgt_fiq), .stk_bank(tgt_stk),
        .has_saved(tgt_has), .saved_slot(tgt_slot)
    );

    brf_gpr_store #(.DW(32)) u_store (
        .clk(clk), .rst_n(rst_n), .is_fiq(cur_fiq), .stk_bank(cur_stk),
        .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
        .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .pc_inc(pc_inc)
    );

    brf_psr_unit #(.DW(32)) u_psr (
        .clk(clk), .rst_n(rst_n),
        .cur_has_saved(cur_has), .cur_slot(cur_slot),
        .tgt_has_saved(tgt_has), .tgt_slot(tgt_slot),
        .exc_enter(exc_enter), .exc_mode(exc_mode),
        .psr_wr_en(psr_wr_en), .psr_wr_data(psr_wr_data),
        .saved_wr_en(saved_wr_en), .saved_wr_data(saved_wr_data),
        .psr_q(psr_q), .saved_q(saved_q)
    );

    // R5
    tgt_decode_consistent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_fiq |-> tgt_has) and (cur_fiq |-> cur_stk == BANK_W'(1)));
endmodule

// File: tb/banked_regfile_tb_top.sv
module banked_regfile_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
    logic [31:0] rd_data_a, rd_data_b, psr_q, saved_q;
    logic        wr_en = 0, pc_inc = 0, psr_wr_en = 0, saved_wr_en = 0, exc_enter = 0;
    logic [31:0] wr_data = '0, psr_wr_data = '0, saved_wr_data = '0;
    logic [4:0]  exc_mode = '0;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    banked_regfile dut_i (
        .clk(clk), .rst_n(rst_n),
        .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
        .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .pc_inc(pc_inc),
        .psr_wr_en(psr_wr_en), .psr_wr_data(psr_wr_data), .psr_q(psr_q),
        .saved_wr_en(saved_wr_en), .saved_wr_data(saved_wr_data), .saved_q(saved_q),
        .exc_enter(exc_enter), .exc_mode(exc_mode)
    );

    // Reference state built from the requirements
    logic [31:0] m_lo [8];
    logic [31:0] m_hi [2][5];
    logic [31:0] m_stk [6][2];
    logic [31:0] m_pc, m_cpsr;
    logic [31:0] m_sv [5];

    logic [4:0] mode_list [8] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
                                  5'b10111, 5'b11011, 5'b11111, 5'b00000};

    function automatic int stk_of(logic [4:0] m);
        case (m)
            5'b10001: return 1;
            5'b10010: return 2;
            5'b10011: return 3;
            5'b10111: return 4;
            5'b11011: return 5;
            default:  return 0;
        endcase
    endfunction

    function automatic int sv_of(logic [4:0] m);
        case (m)
            5'b10001: return 0;
            5'b10010: return 1;
            5'b10011: return 2;
            5'b10111: return 3;
            5'b11011: return 4;
            default:  return -1;
        endcase
    endfunction

    function automatic logic [31:0] m_read(logic [3:0] a);
        logic [4:0] m = m_cpsr[4:0];
        if (a < 4'd8)  return m_lo[a];
        if (a < 4'd13) return m_hi[(m == 5'b10001) ? 1 : 0][int'(a) - 8];
        if (a < 4'd15) return m_stk[stk_of(m)][int'(a) - 13];
        return m_pc + 32'd8;
    endfunction

    function automatic logic [31:0] m_saved();
        int s = sv_of(m_cpsr[4:0]);
        return (s < 0) ? 32'd0 : m_sv[s];
    endfunction

    function automatic string tag_of(logic [3:0] a);
        if (a < 4'd8)  return "R2";
        if (a < 4'd13) return "R3";
        if (a < 4'd15) return "R4";
        return "R6";
    endfunction

    task automatic m_reset();
        foreach (m_lo[i]) m_lo[i] = '0;
        foreach (m_hi[i, j]) m_hi[i][j] = '0;
        foreach (m_stk[i, j]) m_stk[i][j] = '0;
        foreach (m_sv[i]) m_sv[i] = '0;
        m_pc = '0;
        m_cpsr = 32'h13;
    endtask

    task automatic m_step();
        logic [4:0] m = m_cpsr[4:0];
        int cur_sv = sv_of(m);
        int tgt_sv = sv_of(exc_mode);
        if (wr_en && wr_addr == 4'd15) m_pc = wr_data;
        else if (pc_inc) m_pc = m_pc + 32'd4;
        if (wr_en && wr_addr != 4'd15) begin
            if (wr_addr < 4'd8) m_lo[wr_addr] = wr_data;
            else if (wr_addr < 4'd13) m_hi[(m == 5'b10001) ? 1 : 0][int'(wr_addr) - 8] = wr_data;
            else m_stk[stk_of(m)][int'(wr_addr) - 13] = wr_data;
        end
        if (exc_enter && tgt_sv >= 0) begin
            m_sv[tgt_sv] = m_cpsr;
            m_cpsr[4:0] = exc_mode;
        end else begin
            if (saved_wr_en && cur_sv >= 0) m_sv[cur_sv] = saved_wr_data;
            if (psr_wr_en) m_cpsr = psr_wr_data;
        end
    endtask

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %08h expected %08h", tag, what, act, exp);
        end
    endtask

    // Compare outputs before the edge, advance one clock, update the model.
    task automatic tick(string tag);
        #2;
        chk((tag != "") ? tag : tag_of(rd_addr_a), "port A", rd_data_a, m_read(rd_addr_a));
        chk((tag != "") ? tag : ((rd_addr_b == 4'd15) ? "R6" : "R11"), "port B", rd_data_b, m_read(rd_addr_b));
        chk((tag != "") ? tag : "R10", "status", psr_q, m_cpsr);
        chk((tag != "") ? tag : "R9", "saved", saved_q, m_saved());
        @(posedge clk);
        m_step();
        @(negedge clk);
        wr_en = 0; pc_inc = 0; psr_wr_en = 0; saved_wr_en = 0; exc_enter = 0;
    endtask

    task automatic set_mode(logic [4:0] m);
        psr_wr_en = 1; psr_wr_data = {27'h0, m};
        tick("R5");
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d, string tag);
        wr_en = 1; wr_addr = a; wr_data = d;
        tick(tag);
    endtask

    task automatic rd(logic [3:0] a, logic [3:0] b, string tag);
        rd_addr_a = a; rd_addr_b = b;
        tick(tag);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
    end

    initial begin
        void'($urandom(32'd2024));
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset state on all visible registers and status
        for (int a = 0; a < 16; a++) rd(4'(a), 4'(15 - a), "R1");

        // R2: shared low register seen across modes
        wr(4'd3, 32'hA5A5_0003, "R2");
        set_mode(5'b10000);
        rd(4'd3, 4'd3, "R2");
        set_mode(5'b10001);
        rd(4'd3, 4'd7, "R2");

        // R3: fast-interrupt copy of 8..12
        wr(4'd9, 32'hF1F1_0009, "R3");
        set_mode(5'b10010);
        rd(4'd9, 4'd12, "R3");
        wr(4'd9, 32'h1111_0009, "R3");
        set_mode(5'b10001);
        rd(4'd9, 4'd8, "R3");

        // R4: six stack/link copies, user and system shared
        set_mode(5'b10000);
        wr(4'd13, 32'h0000_5013, "R4");
        set_mode(5'b11111);
        rd(4'd13, 4'd14, "R4");
        wr(4'd14, 32'h0000_5F14, "R4");
        set_mode(5'b10111);
        rd(4'd13, 4'd14, "R4");
        wr(4'd13, 32'hABAB_0013, "R4");
        set_mode(5'b11011);
        rd(4'd13, 4'd14, "R4");

        // R5: unlisted code falls back to user copies, no saved slot
        set_mode(5'b00101);
        rd(4'd13, 4'd14, "R5");

        // R6: program counter load, read-ahead, increment
        wr(4'd15, 32'h0000_1000, "R6");
        rd(4'd15, 4'd15, "R6");
        pc_inc = 1; rd_addr_a = 4'd15; tick("R6");
        wr_en = 1; wr_addr = 4'd15; wr_data = 32'h0000_2000; pc_inc = 1; tick("R6");
        rd(4'd15, 4'd0, "R6");

        // R7: same-cycle read returns old value
        rd_addr_a = 4'd5; rd_addr_b = 4'd5;
        wr_en = 1; wr_addr = 4'd5; wr_data = 32'h7777_0005; tick("R7");
        rd(4'd5, 4'd5, "R7");

        // R9: saved write in user/system ignored, then observed from exception modes
        set_mode(5'b10000);
        saved_wr_en = 1; saved_wr_data = 32'hDEAD_BEEF; tick("R9");
        set_mode(5'b11111);
        saved_wr_en = 1; saved_wr_data = 32'hDEAD_BEEF; tick("R9");
        foreach (mode_list[i]) set_mode(mode_list[i]);
        set_mode(5'b10011);
        saved_wr_en = 1; saved_wr_data = 32'h5555_0013; tick("R9");
        rd(4'd0, 4'd1, "R9");

        // R8 / R10: exception entry with colliding status writes
        set_mode(5'b10000);
        psr_q_word: begin
            psr_wr_en = 1; psr_wr_data = 32'hC000_0010; tick("R8");
        end
        exc_enter = 1; exc_mode = 5'b10010;
        psr_wr_en = 1; psr_wr_data = 32'h0000_001F;
        saved_wr_en = 1; saved_wr_data = 32'h1234_5678; tick("R10");
        rd(4'd13, 4'd14, "R8");
        exc_enter = 1; exc_mode = 5'b10001; saved_wr_en = 1; saved_wr_data = 32'h9999_0000; tick("R10");
        rd(4'd8, 4'd13, "R8");
        // invalid target: strobe ignored, status write proceeds
        exc_enter = 1; exc_mode = 5'b11111;
        psr_wr_en = 1; psr_wr_data = 32'h0000_0013; tick("R8");
        rd(4'd0, 4'd13, "R8");

        // R11 plus mixed traffic
        for (int n = 0; n < 3000; n++) begin
            rd_addr_a = 4'($urandom % 16);
            rd_addr_b = 4'($urandom % 16);
            wr_en = 1'($urandom % 2);
            wr_addr = 4'($urandom % 16);
            if (wr_addr == 4'd15 && ($urandom % 4) != 0) wr_addr = 4'd14;
            wr_data = $urandom;
            pc_inc = 1'($urandom % 2);
            psr_wr_en = (($urandom % 6) == 0);
            psr_wr_data = {27'($urandom), mode_list[$urandom % 8]};
            saved_wr_en = (($urandom % 4) == 0);
            saved_wr_data = $urandom;
            exc_enter = (($urandom % 12) == 0);
            exc_mode = mode_list[$urandom % 8];
            tick("");
        end

        summary();
    end
endmodule